// File: doc/BRIEF.md
# Looping Packet Traffic Generator

This block replays a small preloaded buffer of transmit words onto a valid/ready streaming output, so that a link or a downstream datapath can be loaded with a repeatable traffic pattern. Software first fills the buffer through a simple write port. Each entry carries a data word and an end-of-packet flag. Software then sets a pass length, a run mode, a pass count and an idle gap, and pulses start. One pass emits buffer words 0 up to length-1 in order. The final word of a pass always closes a packet.

In counted mode the block makes the programmed number of passes and then finishes, raising a one-cycle done pulse. In continuous mode the pass count is ignored and the buffer is replayed until a stop pulse arrives. A stop always waits for the current packet to complete. A programmable number of idle cycles separates consecutive passes.

Three 32-bit performance counters run alongside the traffic: packets accepted downstream, completion strobes received, and clock cycles spent busy. Software derives the write bandwidth as packets × packet size / (elapsed × clock period), and the read bandwidth the same way from completions and the completion size. The counters can be cleared while traffic keeps flowing. Starting a run also clears them, so in counted mode they cover the whole run.

Top module: `pkt_loop_gen`

## Requirements
- R1: After reset, tx_valid, busy and done are 0 and all three counters read 0.
- R2: Each pass presents buffer entries 0 to ctl_len-1 in address order. tx_data is the word written at that address. tx_last is 1 when the entry was written with buf_wr_last=1, or when it is entry ctl_len-1.
- R3: With ctl_mode=0 (counted), exactly ctl_cycles passes are sent. In the cycle after the final beat is accepted, busy is 0 and done is 1, and done stays high for that one cycle only. A start pulse while busy is ignored.
- R4: With ctl_mode=0 and ctl_cycles=0, no beat is sent and busy never rises. done pulses in the cycle after the start is sampled, and the counters read 0.
- R5: With ctl_mode=1 (continuous), ctl_cycles has no effect. Passes repeat, and busy stays 1 until a stop takes effect. A run ended by stop gives no done pulse.
- R6: Between the accepted final beat of one pass and the first valid beat of the next, tx_valid is low for exactly ctl_gap cycles. With ctl_gap=0 the passes are back to back.
- R7: A stop pulse during a run ends it right after the accepted beat that has tx_last=1. During a gap it ends the run at once. A stop pulse while idle has no effect on the next run.
- R8: While tx_valid is 1 and tx_ready is 0, tx_valid, tx_data and tx_last hold their values into the next cycle.
- R9: cnt_tx_pkts increments once for each accepted beat with tx_last=1.
- R10: cnt_rx_cpl increments once for each cycle in which cpl_strobe is 1, whether or not a run is active.
- R11: cnt_elapsed increments once for each cycle in which busy is 1, and holds its value while busy is 0.
- R12: A ctl_cnt_clr pulse, or an accepted start, sets all three counters to 0 in the following cycle. Clear takes precedence over an increment in the same cycle, and traffic is not interrupted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_start | input | 1 | Start pulse, taken only while idle |
| ctl_stop | input | 1 | Stop pulse, applied at the next packet end |
| ctl_mode | input | 1 | 0 = counted passes, 1 = continuous |
| ctl_cycles | input | 16 | Pass count for counted mode |
| ctl_gap | input | 16 | Idle cycles between passes |
| ctl_len | input | 5 | Words per pass (1 to 16) |
| ctl_cnt_clr | input | 1 | Clears all performance counters |
| buf_wr_en | input | 1 | Buffer write enable |
| buf_wr_addr | input | 4 | Buffer write address |
| buf_wr_data | input | 32 | Buffer write data |
| buf_wr_last | input | 1 | End-of-packet flag stored with the word |
| tx_valid | output | 1 | Output beat valid |
| tx_ready | input | 1 | Downstream ready |
| tx_data | output | 32 | Output beat data |
| tx_last | output | 1 | Final beat of a packet |
| cpl_strobe | input | 1 | One completion received |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when a counted run completes |
| cnt_tx_pkts | output | 32 | Packets accepted downstream |
| cnt_rx_cpl | output | 32 | Completions received |
| cnt_elapsed | output | 32 | Cycles spent busy |

## Verification
Two kinds of internal fault show up on the output at the very next handshake: a read pointer that skips or repeats an entry, and a pass-end decision taken at the wrong index. The scoreboard sees either as a wrong tx_data or tx_last. A wrong gap counter or a wrong pass counter changes the number of idle cycles or the number of passes. The bench sees this either when the next pass begins or when busy falls, which is at most one pass later. A faulty stop latch or counter enable shows up in the cycle busy drops. There the bench compares the last accepted beat, the done pulse and the counters with values it derives on its own from the busy cycles and packets it has observed.

// File: rtl/plg_pkg.sv
package plg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } seq_st_e;

    typedef enum logic {
        MODE_COUNTED    = 1'b0,
        MODE_CONTINUOUS = 1'b1
    } run_mode_e;

    localparam int CTR_TX  = 0;
    localparam int CTR_RX  = 1;
    localparam int CTR_EL  = 2;
    localparam int NUM_CTR = 3;

endpackage

// File: rtl/plg_buffer.sv
module plg_buffer #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_addr,
    input  logic [W-1:0]               wr_data,
    input  logic                       wr_last,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [W-1:0]               rd_data,
    output logic                       rd_last
);
    localparam int EW = W + 1;

    logic [EW-1:0] mem_q [DEPTH];

    // Storage array: no reset, written only through the load port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= {wr_last, wr_data};
        end
    end

    logic [EW-1:0] rd_entry;
    always_comb begin
        rd_entry = mem_q[rd_addr];
        rd_data  = rd_entry[W-1:0];
        rd_last  = rd_entry[EW-1];
    end

endmodule

// File: rtl/plg_ctr.sv
module plg_ctr #(
    parameter int CNTW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            inc,
    output logic [CNTW-1:0] cnt
);
    logic [CNTW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    AST_CTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R12
    AST_CTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/plg_seq.sv
module plg_seq
    import plg_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 16,
    parameter int GW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       stop,
    input  run_mode_e                  mode,
    input  logic [CW-1:0]              cycles,
    input  logic [GW-1:0]              gap,
    input  logic [$clog2(DEPTH):0]     len,
    output logic [$clog2(DEPTH)-1:0]   rd_ptr,
    input  logic                       rd_last,
    input  logic                       tx_ready,
    output logic                       tx_valid,
    output logic                       tx_last,
    output logic                       tx_fire,
    output logic                       busy,
    output logic                       done,
    output logic                       run_start
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] LEN_MAX = (AW+1)'(DEPTH);

    typedef struct packed {
        seq_st_e       st;
        logic [AW-1:0] ptr;
        logic [AW:0]   len;
        run_mode_e     mode;
        logic [CW-1:0] left;
        logic [GW-1:0] gap;
        logic [GW-1:0] gcnt;
        logic          stop;
        logic          busy;
        logic          done;
    } seq_regs_t;

    seq_regs_t d, q;

    logic [AW:0] last_idx;
    logic        end_pass;
    logic        pkt_end;
    logic        stop_now;
    logic        fire;
    logic        finish;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        run_start = 1'b0;
        finish    = 1'b0;
        last_idx  = q.len - (AW+1)'(1);
        end_pass  = ({1'b0, q.ptr} == last_idx);
        pkt_end   = rd_last | end_pass;
        stop_now  = q.stop | stop;
        fire      = (q.st == ST_SEND) & tx_ready;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    run_start = 1'b1;
                    if ((len == '0) || ((mode == MODE_COUNTED) && (cycles == '0))) begin
                        d.done = (mode == MODE_COUNTED);
                    end else begin
                        d.st   = ST_SEND;
                        d.ptr  = '0;
                        // lengths beyond the buffer are held to its depth
                        d.len  = (len > LEN_MAX) ? LEN_MAX : len;
                        d.mode = mode;
                        d.left = cycles;
                        d.gap  = gap;
                        d.stop = 1'b0;
                        d.busy = 1'b1;
                    end
                end
            end
            ST_SEND: begin
                if (stop) begin
                    d.stop = 1'b1;
                end
                if (fire) begin
                    if (end_pass) begin
                        d.ptr = '0;
                        if (q.mode == MODE_COUNTED) begin
                            d.left = q.left - CW'(1);
                        end
                        if ((q.mode == MODE_COUNTED) && (q.left == CW'(1))) begin
                            finish = 1'b1;
                            d.done = 1'b1;
                        end else if (stop_now) begin
                            finish = 1'b1;
                        end else if (q.gap != '0) begin
                            d.st   = ST_GAP;
                            d.gcnt = q.gap;
                        end
                    end else if (rd_last && stop_now) begin
                        finish = 1'b1;
                    end else begin
                        d.ptr = q.ptr + AW'(1);
                    end
                end
            end
            ST_GAP: begin
                if (stop_now) begin
                    finish = 1'b1;
                end else begin
                    d.gcnt = q.gcnt - GW'(1);
                    if (q.gcnt == GW'(1)) begin
                        d.st = ST_SEND;
                    end
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase

        if (finish) begin
            d.st   = ST_IDLE;
            d.busy = 1'b0;
            d.stop = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, mode: MODE_COUNTED, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_ptr   = q.ptr;
    assign tx_valid = (q.st == ST_SEND);
    assign tx_last  = (q.st == ST_SEND) & pkt_end;
    assign tx_fire  = fire;
    assign busy     = q.busy;
    assign done     = q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_GAP_HAS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GAP) |-> ((q.mode == MODE_CONTINUOUS) || (q.left != '0))); // R3
    AST_END_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> ($past(q.st == ST_GAP) || $past(tx_valid && tx_ready && tx_last))); // R7
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !tx_valid); // R4

endmodule

// File: rtl/pkt_loop_gen.sv
module pkt_loop_gen
    import plg_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int CW    = 16,
    parameter int GW    = 16,
    parameter int CNTW  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_start,
    input  logic                       ctl_stop,
    input  logic                       ctl_mode,
    input  logic [CW-1:0]              ctl_cycles,
    input  logic [GW-1:0]              ctl_gap,
    input  logic [$clog2(DEPTH):0]     ctl_len,
    input  logic                       ctl_cnt_clr,
    input  logic                       buf_wr_en,
    input  logic [$clog2(DEPTH)-1:0]   buf_wr_addr,
    input  logic [W-1:0]               buf_wr_data,
    input  logic                       buf_wr_last,
    output logic                       tx_valid,
    input  logic                       tx_ready,
    output logic [W-1:0]               tx_data,
    output logic                       tx_last,
    input  logic                       cpl_strobe,
    output logic                       busy,
    output logic                       done,
    output logic [CNTW-1:0]            cnt_tx_pkts,
    output logic [CNTW-1:0]            cnt_rx_cpl,
    output logic [CNTW-1:0]            cnt_elapsed
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0]   rd_ptr;
    logic            rd_last;
    logic            fire;
    logic            run_start;
    logic            ctr_clr;
    logic [NUM_CTR-1:0] ctr_inc;
    logic [CNTW-1:0] ctr_val [NUM_CTR];

    plg_buffer #(.W(W), .DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .wr_en   (buf_wr_en),
        .wr_addr (buf_wr_addr),
        .wr_data (buf_wr_data),
        .wr_last (buf_wr_last),
        .rd_addr (rd_ptr),
        .rd_data (tx_data),
        .rd_last (rd_last)
    );

    plg_seq #(.DEPTH(DEPTH), .CW(CW), .GW(GW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ctl_start),
        .stop      (ctl_stop),
        .mode      (run_mode_e'(ctl_mode)),
        .cycles    (ctl_cycles),
        .gap       (ctl_gap),
        .len       (ctl_len),
        .rd_ptr    (rd_ptr),
        .rd_last   (rd_last),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .tx_fire   (fire),
        .busy      (busy),
        .done      (done),
        .run_start (run_start)
    );

    always_comb begin
        ctr_clr         = run_start | ctl_cnt_clr;
        ctr_inc         = '0;
        ctr_inc[CTR_TX] = fire & tx_last;
        ctr_inc[CTR_RX] = cpl_strobe;
        ctr_inc[CTR_EL] = busy;
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        plg_ctr #(.CNTW(CNTW)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (ctr_clr),
            .inc   (ctr_inc[i]),
            .cnt   (ctr_val[i])
        );
    end

    assign cnt_tx_pkts = ctr_val[CTR_TX];
    assign cnt_rx_cpl  = ctr_val[CTR_RX];
    assign cnt_elapsed = ctr_val[CTR_EL];

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !buf_wr_en) |=>
            (tx_valid && $stable(tx_data) && $stable(tx_last))); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R3

endmodule

// File: tb/sim_pkt_loop_gen.sv
`timescale 1ns/100ps
module sim_pkt_loop_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_start = 0, ctl_stop = 0, ctl_mode = 0, ctl_cnt_clr = 0;
    logic [15:0] ctl_cycles = 0, ctl_gap = 0;
    logic [4:0]  ctl_len = 0;
    logic        buf_wr_en = 0, buf_wr_last = 0;
    logic [3:0]  buf_wr_addr = 0;
    logic [31:0] buf_wr_data = 0;
    logic        tx_valid, tx_last, busy, done;
    logic        tx_ready = 1'b1;
    logic [31:0] tx_data, cnt_tx_pkts, cnt_rx_cpl, cnt_elapsed;
    logic        cpl_strobe = 1'b0;

    always #2.5 clk = ~clk;

    pkt_loop_gen u0 (
        .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
        .ctl_mode(ctl_mode), .ctl_cycles(ctl_cycles), .ctl_gap(ctl_gap),
        .ctl_len(ctl_len), .ctl_cnt_clr(ctl_cnt_clr), .buf_wr_en(buf_wr_en),
        .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data), .buf_wr_last(buf_wr_last),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .cpl_strobe(cpl_strobe), .busy(busy), .done(done), .cnt_tx_pkts(cnt_tx_pkts),
        .cnt_rx_cpl(cnt_rx_cpl), .cnt_elapsed(cnt_elapsed)
    );

    typedef struct { logic [31:0] d; logic l; logic ep; } exp_t;
    exp_t exp_q[$];

    int n_cmp = 0, n_bad = 0;
    int busy_cyc = 0, beats = 0, done_seen = 0;
    int exp_gap = 0, gap_cnt = 0;
    bit gap_run = 0, hold_pend = 0, last_beat_last = 0, rdy_rand = 0;
    logic [31:0] hold_d;
    logic        hold_l;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] bdata [16];
    logic        blast [16];

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // downstream ready pattern
    always @(posedge clk) begin
        #1;
        lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // monitor: pops the scoreboard at each handshake
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cyc++;
            if (done) begin
                done_seen++;
                chk(!busy, "R3 done with busy low", busy, 0);
            end
            if (hold_pend)
                chk(tx_valid && tx_data == hold_d && tx_last == hold_l, "R8 hold while stalled",
                    {tx_valid, tx_last, tx_data}, {1'b1, hold_l, hold_d});
            hold_pend = tx_valid && !tx_ready;
            hold_d    = tx_data;
            hold_l    = tx_last;
            if (!busy) gap_run = 0;
            else if (gap_run) begin
                if (tx_valid) begin
                    chk(gap_cnt == exp_gap, "R6 idle cycles between passes", gap_cnt, exp_gap);
                    gap_run = 0;
                end else gap_cnt++;
            end
            if (tx_valid && tx_ready) begin
                exp_t e;
                beats++;
                last_beat_last = tx_last;
                if (exp_q.size() == 0) chk(0, "R2 unexpected beat", tx_data, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(tx_data == e.d && tx_last == e.l, "R2 beat data/last",
                        {tx_last, tx_data}, {e.l, e.d});
                    if (e.ep) begin gap_run = 1; gap_cnt = 0; end
                end
            end
        end
    end

    task automatic wr_buf(input int a, input logic [31:0] dv, input logic lv);
        @(posedge clk); #1;
        buf_wr_en = 1; buf_wr_addr = a[3:0]; buf_wr_data = dv; buf_wr_last = lv;
        bdata[a] = dv; blast[a] = lv;
        @(posedge clk); #1;
        buf_wr_en = 0;
    endtask

    task automatic push_passes(input int n, input int len);
        for (int p = 0; p < n; p++)
            for (int i = 0; i < len; i++) begin
                exp_t e;
                e.d = bdata[i]; e.l = blast[i] | (i == len - 1); e.ep = (i == len - 1);
                exp_q.push_back(e);
            end
    endtask

    task automatic start_run(input logic m, input int cyc, input int g, input int len);
        @(posedge clk); #1;
        ctl_mode = m; ctl_cycles = cyc[15:0]; ctl_gap = g[15:0]; ctl_len = len[4:0];
        ctl_start = 1;
        @(posedge clk); #1;
        ctl_start = 0;
    endtask

    task automatic pulse_stop();
        @(posedge clk); #1; ctl_stop = 1;
        @(posedge clk); #1; ctl_stop = 0;
    endtask

    task automatic pulse_clr();
        @(posedge clk); #1; ctl_cnt_clr = 1;
        @(posedge clk); #1; ctl_cnt_clr = 0;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic cycles_n(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int b0, d0, e0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!tx_valid && !busy && !done, "R1 outputs idle after reset", {tx_valid, busy, done}, 0);
        chk(cnt_tx_pkts == 0 && cnt_rx_cpl == 0 && cnt_elapsed == 0, "R1 counters zero after reset",
            cnt_tx_pkts + cnt_rx_cpl + cnt_elapsed, 0);

        for (int i = 0; i < 5; i++) wr_buf(i, 32'hC0DE_0000 ^ (i * 32'h1111_0101), i == 1);

        // counted run, 3 passes, gap 4: R2 R3 R6 R9 R11
        exp_gap = 4; push_passes(3, 5);
        b0 = busy_cyc; d0 = done_seen;
        start_run(0, 3, 4, 5);
        wait_end();
        @(negedge clk);
        chk(exp_q.size() == 0, "R3 exact pass count", exp_q.size(), 0);
        chk(done_seen == d0 + 1, "R3 single done pulse", done_seen - d0, 1);
        chk(cnt_tx_pkts == 6, "R9 packet count", cnt_tx_pkts, 6);
        chk(cnt_elapsed == 23 && cnt_elapsed == busy_cyc - b0, "R11 elapsed equals busy cycles",
            cnt_elapsed, 23);
        chk(cnt_rx_cpl == 0, "R10 no completions", cnt_rx_cpl, 0);
        cycles_n(10);
        @(negedge clk);
        chk(cnt_elapsed == 23, "R11 elapsed frozen while idle", cnt_elapsed, 23);

        // counted run, gap 0, stalled output, completions: R6 R8 R10
        wr_buf(1, 32'h5A5A_0001, 0);
        exp_gap = 0; rdy_rand = 1; push_passes(2, 3);
        d0 = done_seen;
        start_run(0, 2, 0, 3);
        for (int s = 0; s < 7; s++) begin
            @(posedge clk); #1 cpl_strobe = 1;
            @(posedge clk); #1 cpl_strobe = 0;
        end
        wait_end();
        @(negedge clk);
        rdy_rand = 0;
        chk(exp_q.size() == 0, "R3 two passes sent", exp_q.size(), 0);
        chk(cnt_tx_pkts == 2, "R9 packet count single-packet passes", cnt_tx_pkts, 2);
        chk(cnt_rx_cpl == 7, "R10 completion count", cnt_rx_cpl, 7);
        chk(done_seen == d0 + 1, "R3 done after second run", done_seen - d0, 1);

        // zero pass count: R4
        b0 = beats; d0 = done_seen; e0 = busy_cyc;
        start_run(0, 0, 3, 3);
        cycles_n(3);
        @(negedge clk);
        chk(done_seen == d0 + 1, "R4 done with zero passes", done_seen - d0, 1);
        chk(beats == b0 && busy_cyc == e0, "R4 no beats and never busy", beats - b0, 0);
        chk(cnt_tx_pkts == 0 && cnt_elapsed == 0, "R4 counters cleared by start",
            cnt_tx_pkts + cnt_elapsed, 0);

        // continuous run with clear and stop: R5 R7 R12
        wr_buf(1, 32'h5A5A_0002, 1);
        exp_gap = 2; push_passes(30, 5);
        d0 = done_seen;
        start_run(1, 1, 2, 5);
        cycles_n(40);
        @(negedge clk);
        chk(busy == 1, "R5 still running past pass count", busy, 1);
        chk(cnt_tx_pkts > 2, "R5 more than one pass", cnt_tx_pkts, 3);
        pulse_clr();
        @(negedge clk);
        chk(cnt_tx_pkts == 0 && cnt_rx_cpl == 0 && cnt_elapsed == 0, "R12 clear zeroes counters",
            cnt_tx_pkts + cnt_rx_cpl + cnt_elapsed, 0);
        cycles_n(20);
        @(negedge clk);
        chk(busy == 1 && cnt_tx_pkts > 0 && cnt_elapsed > 0, "R12 traffic continues after clear",
            cnt_tx_pkts, 1);
        pulse_stop();
        wait_end();
        @(negedge clk);
        chk(!busy, "R7 stop ends run", busy, 0);
        chk(last_beat_last == 1, "R7 run ends on packet boundary", last_beat_last, 1);
        chk(done_seen == d0, "R5 stop gives no done", done_seen - d0, 0);
        chk(!tx_valid, "R7 no beat after stop", tx_valid, 0);
        exp_q.delete();

        // stop while idle ignored: R7
        pulse_stop();
        exp_gap = 0; push_passes(1, 5);
        start_run(0, 1, 0, 5);
        wait_end();
        @(negedge clk);
        chk(exp_q.size() == 0 && cnt_tx_pkts == 2, "R7 idle stop has no effect", cnt_tx_pkts, 2);

        cycles_n(3);
        summary();
        $finish;
    end

endmodule